// File: doc/BRIEF.md
# Condition Flags and Branch Evaluator

This block works out the difference of two operands, derives the negative, zero, carry and overflow flags of that subtraction, and keeps them in a small flag register. The register loads only on a cycle where the set-flags strobe is high, so the flags persist across any number of cycles that do not set them. Alongside the register, a combinational evaluator compares a 5-bit condition code with the held flags and raises a branch-taken signal. A pipeline uses it by issuing a flag-setting compare and then presenting a conditional branch's condition code in any later cycle.

Carry follows the subtract convention: it is the carry out of `A + ~B + 1`, so it is 1 when no unsigned borrow occurs. The difference output is combinational from the operands. The flags output and the condition result both come from the register, so a compare's effect on them shows up one clock edge after it is strobed.

The block has no state machine. Its only sequential element is the flag register, which has two conditions. RESET clears it to zero. HOLD keeps its value on every edge where `set_flags` is low. LOAD is the transition taken on an edge where `set_flags` is high, and it captures the newly computed flags.

Top module: `cond_branch_unit`

## Requirements
- R1: `diff_out` equals `op_a - op_b` modulo 2^WIDTH, combinationally.
- R2: After a load, the N flag (`flags_out[3]`) equals bit WIDTH-1 of the loaded difference. The Z flag (`flags_out[2]`) is 1 exactly when that difference was zero.
- R3: After a load, the C flag (`flags_out[1]`) is 1 exactly when `op_a >= op_b` as unsigned numbers, meaning no borrow occurred.
- R4: After a load, the V flag (`flags_out[0]`) is 1 exactly when the operand signs differ and the difference's sign differs from `op_a`'s sign.
- R5: While `rst_n` is low, `flags_out` is 4'b0000.
- R6: `flags_out` changes only on a clock edge where `set_flags` was high. Otherwise it holds its value whatever the operands do.
- R7: `cond_true` for codes 0 to 7 tests one flag each: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0.
- R8: Code 8 is true when C=1 and Z=0. Code 9 is true when C=0 or Z=1.
- R9: Code 10 is true when N equals V. Code 11 is true when N differs from V. Comparing 1 with 1 or 1 with 0 makes code 11 false, and comparing 0 with 1 makes it true.
- R10: Code 12 is true when Z=0 and N equals V. Code 13 is its inverse.
- R11: Codes 14 and 15 are always true.
- R12: Codes 16 to 31 are always false.
- R13: `cond_true` follows `cond_code` combinationally against the held flags, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | Minuend |
| op_b | input | WIDTH | Subtrahend |
| set_flags | input | 1 | Load the flag register at the next rising edge |
| cond_code | input | 5 | Condition to evaluate |
| diff_out | output | WIDTH | op_a minus op_b |
| flags_out | output | 4 | Held flags {N, Z, C, V} |
| cond_true | output | 1 | Condition met by the held flags |

## Verification
The assertions assume that the operands and the strobe are stable around each rising edge. They also assume that `diff_out` in the cycle of a load belongs to the same operands that are loaded. The bench meets both assumptions by changing every input on the falling edge only.

The stimulus sweeps every pair drawn from a set of signed and unsigned boundary values. For each pair it sweeps all 32 condition codes. It then changes the operands with the strobe low to show that the flags and conditions hold.

// File: rtl/cond_pkg.sv
`timescale 1ns/1ps
package cond_pkg;
    localparam int COND_W = 5;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [COND_W-1:0] {
        C_EQUAL  = 5'd0,
        C_NOTEQ  = 5'd1,
        C_UGE    = 5'd2,
        C_ULT    = 5'd3,
        C_NEG    = 5'd4,
        C_NONNEG = 5'd5,
        C_OVF    = 5'd6,
        C_NOOVF  = 5'd7,
        C_UGT    = 5'd8,
        C_ULE    = 5'd9,
        C_SGE    = 5'd10,
        C_SLT    = 5'd11,
        C_SGT    = 5'd12,
        C_SLE    = 5'd13,
        C_ALW0   = 5'd14,
        C_ALW1   = 5'd15
    } cond_e;
endpackage

// File: rtl/sub_flags_unit.sv
`timescale 1ns/1ps
module sub_flags_unit
    import cond_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] diff_o,
    output flags_t           flags_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] sum_ext;

    always_comb begin
        // Two's-complement subtract; bit WIDTH is the carry (no-borrow) out.
        sum_ext   = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};
        diff_o    = sum_ext[MSB:0];
        flags_o.n = sum_ext[MSB];
        flags_o.z = (sum_ext[MSB:0] == '0);
        flags_o.c = sum_ext[WIDTH];
        flags_o.v = (a_i[MSB] ^ b_i[MSB]) & (sum_ext[MSB] ^ a_i[MSB]);
    end
endmodule

// File: rtl/flag_hold_reg.sv
`timescale 1ns/1ps
module flag_hold_reg
    import cond_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  flags_t next_i,
    output flags_t flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else if (load_i) begin
            flags_o <= next_i;
        end
    end
endmodule

// File: rtl/cond_eval.sv
`timescale 1ns/1ps
module cond_eval
    import cond_pkg::*;
(
    input  logic [COND_W-1:0] code_i,
    input  flags_t            flags_i,
    output logic              taken_o
);
    logic sign_ok;

    always_comb begin
        sign_ok = (flags_i.n == flags_i.v);
        taken_o = 1'b0;
        if (!code_i[COND_W-1]) begin
            unique case (cond_e'(code_i))
                C_EQUAL:  taken_o = flags_i.z;
                C_NOTEQ:  taken_o = !flags_i.z;
                C_UGE:    taken_o = flags_i.c;
                C_ULT:    taken_o = !flags_i.c;
                C_NEG:    taken_o = flags_i.n;
                C_NONNEG: taken_o = !flags_i.n;
                C_OVF:    taken_o = flags_i.v;
                C_NOOVF:  taken_o = !flags_i.v;
                C_UGT:    taken_o = flags_i.c && !flags_i.z;
                C_ULE:    taken_o = !flags_i.c || flags_i.z;
                C_SGE:    taken_o = sign_ok;
                C_SLT:    taken_o = !sign_ok;
                C_SGT:    taken_o = !flags_i.z && sign_ok;
                C_SLE:    taken_o = !(!flags_i.z && sign_ok);
                C_ALW0,
                C_ALW1:   taken_o = 1'b1;
                default:  taken_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cond_branch_unit.sv
`timescale 1ns/1ps
module cond_branch_unit
    import cond_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             set_flags,
    input  logic [4:0]       cond_code,
    output logic [WIDTH-1:0] diff_out,
    output logic [3:0]       flags_out,
    output logic             cond_true
);
    flags_t next_flags;
    flags_t held_flags;

    sub_flags_unit #(.WIDTH(WIDTH)) sub_i (
        .a_i     (op_a),
        .b_i     (op_b),
        .diff_o  (diff_out),
        .flags_o (next_flags)
    );

    flag_hold_reg hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (set_flags),
        .next_i  (next_flags),
        .flags_o (held_flags)
    );

    cond_eval eval_i (
        .code_i  (cond_code),
        .flags_i (held_flags),
        .taken_o (cond_true)
    );

    assign flags_out = held_flags;
endmodule

// File: rtl/cond_branch_chk.sv
`timescale 1ns/1ps
module cond_branch_chk #(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             set_flags,
    input logic [4:0]       cond_code,
    input logic [WIDTH-1:0] diff_out,
    input logic [3:0]       flags_out,
    input logic             cond_true
);
    // R5
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (flags_out == 4'b0000));

    // R6
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> $stable(flags_out));

    // R2
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (flags_out[2] == ($past(diff_out) == '0)));

    // R3
    no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (flags_out[1] == ($past(op_a) >= $past(op_b))));

    // R9
    signed_less_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 5'd11) |-> (cond_true == (flags_out[3] ^ flags_out[0])));

    // R11
    always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code[4:1] == 4'b0111) |-> cond_true);

    // R12
    upper_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_code[4] |-> !cond_true);
endmodule

bind cond_branch_unit cond_branch_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .set_flags (set_flags),
    .cond_code (cond_code),
    .diff_out  (diff_out),
    .flags_out (flags_out),
    .cond_true (cond_true)
);

// File: tb/cond_branch_unit_tb_top.sv
`timescale 1ns/1ps
module cond_branch_unit_tb_top;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         set_flags = 1'b0;
    logic [4:0]   cond_code = '0;
    logic [W-1:0] diff_out;
    logic [3:0]   flags_out;
    logic         cond_true;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [W-1:0] corners [8];

    cond_branch_unit #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .set_flags(set_flags), .cond_code(cond_code),
        .diff_out(diff_out), .flags_out(flags_out), .cond_true(cond_true)
    );

    always #2 clk = ~clk;

    function automatic logic [3:0] ref_flags(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        logic n, z, c, v;
        s = {1'b0, a} + {1'b0, ~b} + 1;
        n = s[W-1];
        z = (s[W-1:0] == '0);
        c = s[W];
        v = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
        return {n, z, c, v};
    endfunction

    function automatic logic ref_cond(input logic [4:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        if (cc >= 5'd16) return 1'b0;
        case (cc)
            5'd0:  return z;
            5'd1:  return !z;
            5'd2:  return c;
            5'd3:  return !c;
            5'd4:  return n;
            5'd5:  return !n;
            5'd6:  return v;
            5'd7:  return !v;
            5'd8:  return c && !z;
            5'd9:  return !c || z;
            5'd10: return n == v;
            5'd11: return n != v;
            5'd12: return !z && (n == v);
            5'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string cond_req(input logic [4:0] cc);
        if (cc >= 5'd16) return "R12";
        if (cc >= 5'd14) return "R11";
        if (cc >= 5'd12) return "R10";
        if (cc >= 5'd10) return "R9";
        if (cc >= 5'd8)  return "R8";
        return "R7";
    endfunction

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Load a compare, then verify difference, flags and every condition.
    task automatic run_pair(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [3:0] ef;
        ef = ref_flags(a, b);
        @(negedge clk);
        op_a = a; op_b = b; set_flags = 1'b1;
        #1;
        check("R1 diff", diff_out, a - b);
        @(negedge clk);
        set_flags = 1'b0;
        #1;
        check("R2 N", {63'd0, flags_out[3]}, {63'd0, ef[3]});
        check("R2 Z", {63'd0, flags_out[2]}, {63'd0, ef[2]});
        check("R3 C", {63'd0, flags_out[1]}, {63'd0, (a >= b)});
        check("R4 V", {63'd0, flags_out[0]}, {63'd0, ef[0]});
        for (int k = 0; k < 32; k++) begin
            cond_code = 5'(k);
            #0.25;
            // R13: no edge between code change and sample
            check(cond_req(5'(k)), {63'd0, cond_true}, {63'd0, ref_cond(5'(k), ef)});
        end
        // R6: new operands with strobe low must leave the flags alone
        @(negedge clk);
        op_a = ~a; op_b = a ^ 64'h5;
        @(negedge clk);
        #1;
        check("R6 hold", {60'd0, flags_out}, {60'd0, ef});
        cond_code = 5'd11;
        #0.25;
        check("R6 cond hold", {63'd0, cond_true}, {63'd0, ref_cond(5'd11, ef)});
    endtask

    initial begin
        corners[0] = 64'd0;
        corners[1] = 64'd1;
        corners[2] = 64'd2;
        corners[3] = 64'h7FFF_FFFF_FFFF_FFFF;
        corners[4] = 64'h8000_0000_0000_0000;
        corners[5] = 64'h8000_0000_0000_0001;
        corners[6] = 64'hFFFF_FFFF_FFFF_FFFF;
        corners[7] = 64'hFFFF_FFFF_FFFF_FFFE;

        // R5: reset state, even with the strobe high
        set_flags = 1'b1; op_a = 64'd0; op_b = 64'd1;
        repeat (3) @(negedge clk);
        #1;
        check("R5 reset", {60'd0, flags_out}, 60'd0 << 4);
        set_flags = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R5 after release", {60'd0, flags_out}, 64'd0);

        // R9: signed-less cases from small compares
        run_pair(64'd1, 64'd1);
        check("R9 1-1", {63'd0, cond_true}, 64'd0);
        run_pair(64'd1, 64'd0);
        check("R9 1-0", {63'd0, cond_true}, 64'd0);
        run_pair(64'd0, 64'd1);
        check("R9 0-1", {63'd0, cond_true}, 64'd1);

        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                run_pair(corners[i], corners[j]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<200000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule